// File: doc/BRIEF.md
# Half to single precision widening converter

The block takes one 16-bit half-precision operand together with the floating-point control fields that govern a conversion. It produces the matching 32-bit single-precision value one clock after a valid strobe. The control fields are flush-to-zero, default-NaN, alternative half format, the underflow trap enable, the rounding mode and a per-exception trap-enable vector. The block classifies the operand as zero, finite, infinity, quiet NaN or signaling NaN, re-biases the exponent, and normalises half subnormals into single normals. It passes NaN payloads through, or replaces them with the default NaN.

Each exception either requests a trap or sets a sticky status bit, chosen by that exception's enable bit. The status vector accumulates across conversions until a synchronous clear. Every finite half value has an exact single-precision form. Because of this, the rounding mode, flush-to-zero and the underflow trap enable never change the result. The only exception the block can raise is invalid operation, and it raises it for a signaling NaN operand. When the alternative half format is selected, the top exponent code stands for ordinary normal numbers up to 131008.

Top module: `h2s_convert`

## Requirements
- R1: A half operand with exponent 0 and fraction 0 converts to a zero of the same sign (0x0000 gives 0x00000000, 0x8000 gives 0x80000000).
- R2: A half normal (exponent 1..30, bias 15, sign bit 15, exponent bits 14:10, fraction bits 9:0) converts exactly: single exponent = half exponent + 112, fraction = half fraction shifted left by 13 (0x3C00 gives 0x3F800000).
- R3: A half subnormal (exponent 0, fraction f nonzero, value f x 2^-24) converts to the exact normalised single value (0x0001 gives 0x33800000, 0x83FF gives 0xB87FC000).
- R4: With the alternative-format control set, exponent 31 is decoded as a normal number with exponent 31 (0x7C00 gives 0x47800000, 0xFFFF gives 0xC7FFE000); with it clear, exponent 31 means infinity or NaN.
- R5: A half infinity (exponent 31, fraction 0, alternative format clear) converts to the single infinity of the same sign (0x7F800000 / 0xFF800000).
- R6: A half NaN with the default-NaN control clear converts to sign in bit 31, ORed with 0x7FC00000, with the low 9 half fraction bits placed in bits 21:13 (0xFD55 gives 0xFFEAA000).
- R7: A half NaN with the default-NaN control set converts to 0x7FC00000.
- R8: A half NaN is signaling when fraction bit 9 is 0; a signaling NaN raises invalid operation (exception index 0), and a quiet NaN or any non-NaN operand raises none.
- R9: A raised exception k with trap-enable bit k set pulses trap_req for exactly the cycle the result appears and leaves status bit k unchanged; with the enable clear it sets status bit k, which stays set across later conversions.
- R10: stat_clr zeroes the status vector on the next edge; an exception raised in the same cycle as the clear is still recorded.
- R11: The rounding mode, flush-to-zero and underflow trap enable have no effect on the result, and status bits other than bit 0 never set.
- R12: The result and out_valid appear one cycle after in_valid; the result holds while no new operand arrives, and the status vector changes only on valid or clear cycles. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_half | input | 16 | Half-precision operand |
| ctl_rmode | input | 2 | Rounding mode (no effect) |
| ctl_fz | input | 1 | Flush-to-zero (no effect) |
| ctl_dn | input | 1 | Default-NaN select |
| ctl_ahp | input | 1 | Alternative half format select |
| ctl_ufe | input | 1 | Underflow trap enable (no effect) |
| trap_en | input | 8 | Trap enable per exception index |
| stat_clr | input | 1 | Synchronous clear of the status vector |
| out_valid | output | 1 | Result strobe |
| out_single | output | 32 | Single-precision result |
| stat_flags | output | 8 | Sticky exception status, bit = exception index |
| trap_req | output | 1 | Trap request pulse |

## Verification
The hardest cases to reach are the interactions around the sticky status vector. One is a clear that coincides with a signaling NaN. Another is a trap-enabled signaling NaN, which must leave the status untouched while it pulses trap_req. Directed tasks set the clear and the operand in the same cycle, and toggle trap_en between back-to-back signaling NaNs. A streaming sweep of all 65536 codes is then compared against a reference written as a shift-until-normalised loop. That sweep covers every subnormal leading-one position and every NaN payload. A second sweep over the top exponent code covers the alternative format.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
  localparam int HALF_W    = 16;
  localparam int HEXP_W    = 5;
  localparam int HFRAC_W   = 10;
  localparam int SGL_W     = 32;
  localparam int SEXP_W    = 8;
  localparam int SFRAC_W   = 23;
  localparam int EXC_W     = 8;
  localparam int EXC_INVALID = 0;
  localparam int LZ_W      = $clog2(HFRAC_W);
  localparam int FRAC_PAD  = SFRAC_W - HFRAC_W;
  // half bias 15, single bias 127: difference added to a normal exponent
  localparam logic [SEXP_W-1:0] REBIAS = 8'd112;
  localparam logic [SGL_W-1:0]  QNAN_BASE = 32'h7FC0_0000;

  typedef enum logic [2:0] {
    CLS_FINITE,
    CLS_SUBN,
    CLS_ZERO,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } fp_class_e;

  // count of zeros above the leading one of a nonzero fraction
  function automatic logic [LZ_W-1:0] lead_zeros(input logic [HFRAC_W-1:0] f);
    logic [LZ_W-1:0] n;
    logic            found;
    n = '0;
    found = 1'b0;
    for (int i = HFRAC_W - 1; i >= 0; i--) begin
      if (!found && f[i]) begin
        n = LZ_W'(HFRAC_W - 1 - i);
        found = 1'b1;
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/h2s_classify.sv
module h2s_classify
  import h2s_pkg::*;
(
  input  logic [HALF_W-1:0]  half,
  input  logic               alt_fmt,
  output fp_class_e          cls,
  output logic               sign,
  output logic [HEXP_W-1:0]  exp_f,
  output logic [HFRAC_W-1:0] frac
);
  logic exp_max;
  logic exp_min;

  assign sign    = half[HALF_W-1];
  assign exp_f   = half[HALF_W-2 -: HEXP_W];
  assign frac    = half[HFRAC_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;

  always_comb begin
    if (exp_min)
      cls = (frac == '0) ? CLS_ZERO : CLS_SUBN;
    else if (exp_max && !alt_fmt) begin
      if (frac == '0)
        cls = CLS_INF;
      else
        cls = frac[HFRAC_W-1] ? CLS_QNAN : CLS_SNAN;
    end else
      cls = CLS_FINITE;
  end
endmodule

// File: rtl/h2s_widen.sv
module h2s_widen
  import h2s_pkg::*;
(
  input  fp_class_e          cls,
  input  logic               sign,
  input  logic [HEXP_W-1:0]  exp_f,
  input  logic [HFRAC_W-1:0] frac,
  input  logic               dflt_nan,
  output logic [SGL_W-1:0]   result
);
  logic [LZ_W-1:0]    lz;
  logic [HFRAC_W-1:0] frac_n;
  logic [SEXP_W-1:0]  sub_exp;
  logic [HFRAC_W-1:0] sub_frac;

  assign lz       = lead_zeros(frac);
  assign frac_n   = frac << lz;
  // drop the leading one that becomes the hidden bit
  assign sub_frac = {frac_n[HFRAC_W-2:0], 1'b0};
  assign sub_exp  = REBIAS - SEXP_W'(lz);

  always_comb begin
    unique case (cls)
      CLS_ZERO:   result = {sign, {(SGL_W-1){1'b0}}};
      CLS_INF:    result = {sign, {SEXP_W{1'b1}}, {SFRAC_W{1'b0}}};
      CLS_QNAN,
      CLS_SNAN:   result = dflt_nan ? QNAN_BASE
                         : ({sign, {(SGL_W-1){1'b0}}} | QNAN_BASE |
                            {9'b0, frac[HFRAC_W-2:0], {FRAC_PAD{1'b0}}});
      CLS_SUBN:   result = {sign, sub_exp, sub_frac, {FRAC_PAD{1'b0}}};
      default:    result = {sign, SEXP_W'(exp_f) + REBIAS, frac, {FRAC_PAD{1'b0}}};
    endcase
  end
endmodule

// File: rtl/h2s_flags.sv
module h2s_flags #(
  parameter int EXC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             clr,
  input  logic [EXC_W-1:0] exc_vec,
  input  logic [EXC_W-1:0] trap_en,
  output logic [EXC_W-1:0] flags,
  output logic             trap_req
);
  logic [EXC_W-1:0] raised;
  logic [EXC_W-1:0] to_trap;
  logic [EXC_W-1:0] to_flag;

  assign raised  = valid ? exc_vec : '0;
  assign to_trap = raised & trap_en;
  assign to_flag = raised & ~trap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags    <= '0;
      trap_req <= 1'b0;
    end else begin
      flags    <= (clr ? '0 : flags) | to_flag;
      trap_req <= |to_trap;
    end
  end
endmodule

// File: rtl/h2s_convert.sv
module h2s_convert
  import h2s_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [HALF_W-1:0] in_half,
  input  logic [1:0]        ctl_rmode,
  input  logic              ctl_fz,
  input  logic              ctl_dn,
  input  logic              ctl_ahp,
  input  logic              ctl_ufe,
  input  logic [EXC_W-1:0]  trap_en,
  input  logic              stat_clr,
  output logic              out_valid,
  output logic [SGL_W-1:0]  out_single,
  output logic [EXC_W-1:0]  stat_flags,
  output logic              trap_req
);
  fp_class_e          cls;
  logic               sign;
  logic [HEXP_W-1:0]  exp_f;
  logic [HFRAC_W-1:0] frac;
  logic [SGL_W-1:0]   wide;
  logic [EXC_W-1:0]   exc_vec;
  logic               snan_seen;
  logic               unused_ctl;

  // every finite half is exact in single: these controls cannot matter
  assign unused_ctl = ^{ctl_rmode, ctl_fz, ctl_ufe};

  h2s_classify u_cls (
    .half(in_half), .alt_fmt(ctl_ahp),
    .cls(cls), .sign(sign), .exp_f(exp_f), .frac(frac)
  );

  h2s_widen u_wid (
    .cls(cls), .sign(sign), .exp_f(exp_f), .frac(frac),
    .dflt_nan(ctl_dn), .result(wide)
  );

  assign snan_seen = (cls == CLS_SNAN);

  always_comb begin
    exc_vec = '0;
    exc_vec[EXC_INVALID] = snan_seen;
  end

  h2s_flags #(.EXC_W(EXC_W)) u_flg (
    .clk(clk), .rst_n(rst_n), .valid(in_valid), .clr(stat_clr),
    .exc_vec(exc_vec), .trap_en(trap_en),
    .flags(stat_flags), .trap_req(trap_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_single <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid)
        out_single <= wide;
    end
  end
endmodule

// File: rtl/h2s_convert_chk.sv
module h2s_convert_chk
  import h2s_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              stat_clr,
  input logic              out_valid,
  input logic [SGL_W-1:0]  out_single,
  input logic [EXC_W-1:0]  stat_flags,
  input logic              trap_req,
  input logic              snan_seen
);
  // R12
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_single));
  // R12
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !stat_clr |=> $stable(stat_flags));
  // R9
  trap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> out_valid);
  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> ((stat_flags & $past(stat_flags)) == $past(stat_flags)));
  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr && !in_valid |=> stat_flags == '0);
  // R8
  no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !snan_seen && !stat_clr |=> $stable(stat_flags) && !trap_req);
  // R11
  other_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_flags[EXC_W-1:1] == '0);
endmodule

bind h2s_convert h2s_convert_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .stat_clr(stat_clr),
  .out_valid(out_valid), .out_single(out_single), .stat_flags(stat_flags),
  .trap_req(trap_req), .snan_seen(snan_seen)
);

// File: tb/sim_h2s_convert.sv
module sim_h2s_convert;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_half = '0;
  logic [1:0]  ctl_rmode = '0;
  logic        ctl_fz = 1'b0, ctl_dn = 1'b0, ctl_ahp = 1'b0, ctl_ufe = 1'b0;
  logic [7:0]  trap_en = '0;
  logic        stat_clr = 1'b0;
  logic        out_valid;
  logic [31:0] out_single;
  logic [7:0]  stat_flags;
  logic        trap_req;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  h2s_convert u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
    .ctl_rmode(ctl_rmode), .ctl_fz(ctl_fz), .ctl_dn(ctl_dn), .ctl_ahp(ctl_ahp),
    .ctl_ufe(ctl_ufe), .trap_en(trap_en), .stat_clr(stat_clr),
    .out_valid(out_valid), .out_single(out_single), .stat_flags(stat_flags),
    .trap_req(trap_req)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      if (bad < 20)
        $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // independent model: shift the significand until the hidden bit is set
  function automatic logic [31:0] ref_conv(input logic [15:0] h, input logic ahp, input logic dn);
    logic        s;
    logic [4:0]  e;
    logic [9:0]  f;
    logic [10:0] m;
    int          ex;
    s = h[15]; e = h[14:10]; f = h[9:0];
    if (e == 5'd31 && !ahp) begin
      if (f == 0) return {s, 8'hFF, 23'd0};
      if (dn) return 32'h7FC00000;
      return {s, 8'hFF, 1'b1, f[8:0], 13'd0};
    end
    if (e == 0 && f == 0) return {s, 31'd0};
    m  = (e == 0) ? {1'b0, f} : {1'b1, f};
    ex = (e == 0) ? -14 : int'(e) - 15;
    while (!m[10]) begin
      m  = m << 1;
      ex = ex - 1;
    end
    return {s, 8'(ex + 127), m[9:0], 13'd0};
  endfunction

  task automatic apply(input logic [15:0] h, input logic clr);
    @(negedge clk);
    in_half = h; in_valid = 1'b1; stat_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; stat_clr = 1'b0;
  endtask

  task automatic conv_one(input string req, input logic [15:0] h, input logic [31:0] exp);
    apply(h, 1'b0);
    chk(req, $sformatf("in=%h", h), out_single, exp);
  endtask

  task automatic t_reset;
    chk("R12", "reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R12", "reset result", out_single, 32'd0);
    chk("R12", "reset flags", {24'd0, stat_flags}, 32'd0);
    chk("R12", "reset trap", {31'd0, trap_req}, 32'd0);
  endtask

  task automatic t_values;
    conv_one("R1", 16'h0000, 32'h00000000);
    conv_one("R1", 16'h8000, 32'h80000000);
    conv_one("R2", 16'h3C00, 32'h3F800000);
    conv_one("R2", 16'hC000, 32'hC0000000);
    conv_one("R2", 16'h7BFF, 32'h477FE000);
    conv_one("R3", 16'h0001, 32'h33800000);
    conv_one("R3", 16'h83FF, 32'hB87FC000);
    conv_one("R3", 16'h0200, 32'h38000000);
    conv_one("R5", 16'h7C00, 32'h7F800000);
    conv_one("R5", 16'hFC00, 32'hFF800000);
    conv_one("R6", 16'h7E01, 32'h7FC02000);
    conv_one("R6", 16'hFD55, 32'hFFEAA000);
    ctl_dn = 1'b1;
    conv_one("R7", 16'hFD55, 32'h7FC00000);
    conv_one("R7", 16'h7E01, 32'h7FC00000);
    ctl_dn = 1'b0;
    ctl_ahp = 1'b1;
    conv_one("R4", 16'h7C00, 32'h47800000);
    conv_one("R4", 16'hFFFF, 32'hC7FFE000);
    ctl_ahp = 1'b0;
  endtask

  task automatic t_flags;
    apply(16'h3C00, 1'b1);
    chk("R10", "flags after clear", {24'd0, stat_flags}, 32'd0);
    apply(16'h7E00, 1'b0);
    chk("R8", "quiet NaN raises nothing", {24'd0, stat_flags}, 32'd0);
    chk("R8", "quiet NaN no trap", {31'd0, trap_req}, 32'd0);
    apply(16'h7C01, 1'b0);
    chk("R8", "signaling NaN sets invalid", {24'd0, stat_flags}, 32'd1);
    apply(16'h3C00, 1'b0);
    chk("R9", "invalid stays set", {24'd0, stat_flags}, 32'd1);
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    chk("R10", "clear alone", {24'd0, stat_flags}, 32'd0);
    apply(16'h7C01, 1'b1);
    chk("R10", "clear with raise keeps new", {24'd0, stat_flags}, 32'd1);
  endtask

  task automatic t_trap;
    apply(16'h3C00, 1'b1);
    trap_en = 8'h01;
    apply(16'hFC01, 1'b0);
    chk("R9", "trap pulse", {31'd0, trap_req}, 32'd1);
    chk("R9", "trap leaves flag clear", {24'd0, stat_flags}, 32'd0);
    chk("R9", "trap result", out_single, 32'hFFC02000);
    @(negedge clk);
    chk("R9", "trap pulse ends", {31'd0, trap_req}, 32'd0);
    trap_en = 8'hFE;
    apply(16'hFC01, 1'b0);
    chk("R9", "other enables ignored", {24'd0, stat_flags}, 32'd1);
    chk("R9", "no trap when disabled", {31'd0, trap_req}, 32'd0);
    trap_en = 8'h00;
  endtask

  task automatic t_ignored;
    apply(16'h3C00, 1'b1);
    ctl_rmode = 2'd3; ctl_fz = 1'b1; ctl_ufe = 1'b1;
    conv_one("R11", 16'h0001, 32'h33800000);
    conv_one("R11", 16'h3555, ref_conv(16'h3555, 1'b0, 1'b0));
    ctl_rmode = 2'd2;
    conv_one("R11", 16'h8155, ref_conv(16'h8155, 1'b0, 1'b0));
    chk("R11", "no flags raised", {24'd0, stat_flags}, 32'd0);
    ctl_rmode = 2'd0; ctl_fz = 1'b0; ctl_ufe = 1'b0;
  endtask

  task automatic t_timing;
    apply(16'h4000, 1'b0);
    chk("R12", "valid after one cycle", {31'd0, out_valid}, 32'd1);
    in_half = 16'h1234;
    @(negedge clk);
    chk("R12", "valid drops", {31'd0, out_valid}, 32'd0);
    chk("R12", "result held", out_single, 32'h40000000);
  endtask

  task automatic sweep(input logic ahp, input int first, input int last);
    logic [15:0] prev;
    ctl_ahp = ahp;
    @(negedge clk);
    in_half = 16'(first); in_valid = 1'b1; prev = 16'(first);
    for (int i = first + 1; i <= last + 1; i++) begin
      @(negedge clk);
      chk(ahp ? "R4" : "R3", $sformatf("sweep in=%h", prev), out_single, ref_conv(prev, ahp, 1'b0));
      if (i <= last) begin
        in_half = 16'(i); prev = 16'(i);
      end
    end
    in_valid = 1'b0;
    ctl_ahp = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_values();
    t_flags();
    t_trap();
    t_ignored();
    t_timing();
    sweep(1'b0, 0, 65535);
    sweep(1'b1, 16'h7C00, 16'h7FFF);
    sweep(1'b1, 16'hFC00, 16'hFFFF);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule